// File: doc/BRIEF.md
# Time-Gain Compensation DAC Sequencer

This block drives the gain-control code of an ultrasound receiver's variable-gain amplifier so that echo gain can rise as the echoes come from deeper tissue. A small profile of gain codes is loaded through a simple configuration write port. While an acquisition runs, the block steps through the profile. Each entry is applied for a fixed time slot, and the slots are taken in increasing index order. When no acquisition runs, a separately programmed idle code is driven instead.

The code is presented as a registered parallel word, together with a one-cycle load strobe that a downstream serial DAC interface uses to pick up each new value. A gain-range select bit is also held in a register and presented as a static output. With the default parameters there are 16 entries of 9 bits, and each slot lasts 512 cycles of a 64 MHz clock (8 µs). The whole profile therefore covers 128 µs. If the acquisition runs past the last slot, the last entry's code stays on the output until the acquisition ends.

The configuration address space is laid out as follows:
- Addresses 0 to ENTRIES-1 hold the profile entries.
- Address ENTRIES holds the idle code.
- Address ENTRIES+1 holds the range bit, taken from data bit 0.

Top module: `tgc_sequencer`

## Requirements
- R1: While reset is asserted, and until anything is written, `dac_code` is 0, `dac_load` is 0 and `range_hi` is 0.
- R2: A write to address ENTRIES while no acquisition runs sets the idle code, and `dac_code` shows it two cycles after the write cycle.
- R3: When `acq_active` is first sampled high at edge E0, profile entry k appears on `dac_code` after edge E0+2+k*SLOT_CYCLES, and it stays there for SLOT_CYCLES cycles.
- R4: If the acquisition is still running after the last slot, the last entry's code remains on `dac_code` until the acquisition ends.
- R5: When `acq_active` is first sampled low at edge D, `dac_code` returns to the idle code after edge D+2. This holds whether the profile has finished or not.
- R6: `dac_load` is high for exactly the cycles in which `dac_code` holds a value different from the one in the previous cycle, and it is low in every other cycle.
- R7: A write to address ENTRIES+1 copies data bit 0 to `range_hi` one cycle after the write cycle, and `range_hi` holds that value until the next write to that address.
- R8: A write to the profile entry that is currently being driven does not change `dac_code` during that slot. The new value is used the next time a slot reads that entry. Every acquisition starts again from entry 0.
- R9: Writes to addresses above ENTRIES+1 change neither `dac_code` nor `range_hi` nor any stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | $clog2(ENTRIES+2) | Configuration address (profile, idle code, range bit) |
| cfg_wdata | input | CODE_W | Configuration write data |
| acq_active | input | 1 | High for the duration of an acquisition |
| dac_code | output | CODE_W | Registered gain code for the DAC |
| dac_load | output | 1 | One-cycle strobe marking a new code |
| range_hi | output | 1 | Held high/low gain-range select |

## Verification
The bench keeps ENTRIES at 16 and CODE_W at 9, so the full address map, including the unused addresses above the range bit, is exercised at its real size. SLOT_CYCLES is reduced to 8. With slots that short, a full profile walk, the hold on the last entry, an acquisition aborted in the middle of the profile, and a write to a live entry during its own slot all fit within a few hundred cycles. Every code change is checked against the exact cycle predicted from the slot length, so an off-by-one in slot timing or in pipeline latency shows up directly.

// File: rtl/tgc_pkg.sv
package tgc_pkg;

  // Kind of register a configuration address selects
  typedef enum logic [1:0] {
    KIND_PROFILE = 2'd0,
    KIND_IDLE    = 2'd1,
    KIND_RANGE   = 2'd2,
    KIND_NONE    = 2'd3
  } cfg_kind_e;

endpackage

// File: rtl/tgc_ctrl_regs.sv
module tgc_ctrl_regs
  import tgc_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CODE_W  = 9,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = $clog2(ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  output logic              prof_we,
  output logic [IDX_W-1:0]  prof_waddr,
  output logic [CODE_W-1:0] idle_code,
  output logic              range_hi
);

  localparam logic [ADDR_W-1:0] IDLE_ADDR  = ADDR_W'(ENTRIES);
  localparam logic [ADDR_W-1:0] RANGE_ADDR = ADDR_W'(ENTRIES + 1);

  cfg_kind_e kind;

  always_comb begin
    if (cfg_addr < IDLE_ADDR)        kind = KIND_PROFILE;
    else if (cfg_addr == IDLE_ADDR)  kind = KIND_IDLE;
    else if (cfg_addr == RANGE_ADDR) kind = KIND_RANGE;
    else                             kind = KIND_NONE;
  end

  assign prof_we    = cfg_we && (kind == KIND_PROFILE);
  assign prof_waddr = cfg_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_code <= '0;
      range_hi  <= 1'b0;
    end else if (cfg_we) begin
      if (kind == KIND_IDLE)  idle_code <= cfg_wdata;
      if (kind == KIND_RANGE) range_hi  <= cfg_wdata[0];
    end
  end

endmodule

// File: rtl/tgc_profile_mem.sv
module tgc_profile_mem #(
  parameter int ENTRIES = 16,
  parameter int CODE_W  = 9,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [CODE_W-1:0] rdata
);

  // Simple dual-port shape, read with enable, no reset: block RAM friendly
  logic [CODE_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/tgc_slot_timer.sv
module tgc_slot_timer #(
  parameter int ENTRIES     = 16,
  parameter int SLOT_CYCLES = 512,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int CNT_W      = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acq_active,
  output logic             active_q,
  output logic [IDX_W-1:0] slot_idx,
  output logic             slot_load
);

  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(SLOT_CYCLES - 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ENTRIES - 1);

  logic [CNT_W-1:0] cyc_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      cyc_cnt   <= '0;
      slot_idx  <= '0;
      slot_load <= 1'b0;
    end else begin
      active_q  <= acq_active;
      slot_load <= 1'b0;
      if (acq_active && !active_q) begin
        cyc_cnt   <= '0;
        slot_idx  <= '0;
        slot_load <= 1'b1;
      end else if (acq_active) begin
        if (cyc_cnt == LAST_CNT) begin
          cyc_cnt <= '0;
          if (slot_idx != LAST_SLOT) begin
            slot_idx  <= slot_idx + 1'b1;
            slot_load <= 1'b1;
          end
        end else begin
          cyc_cnt <= cyc_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tgc_output_stage.sv
module tgc_output_stage #(
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_q,
  input  logic [CODE_W-1:0] prof_code,
  input  logic [CODE_W-1:0] idle_code,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load
);

  logic              active_d;
  logic [CODE_W-1:0] next_code;

  // active_d lines up with the registered memory read
  assign next_code = active_d ? prof_code : idle_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_d <= 1'b0;
      dac_code <= '0;
      dac_load <= 1'b0;
    end else begin
      active_d <= active_q;
      dac_code <= next_code;
      dac_load <= (next_code != dac_code);
    end
  end

endmodule

// File: rtl/tgc_sequencer.sv
module tgc_sequencer #(
  parameter int ENTRIES     = 16,
  parameter int CODE_W      = 9,
  parameter int SLOT_CYCLES = 512,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int ADDR_W     = $clog2(ENTRIES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              acq_active,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load,
  output logic              range_hi
);

  logic              prof_we;
  logic [IDX_W-1:0]  prof_waddr;
  logic [CODE_W-1:0] idle_code;
  logic              active_q;
  logic [IDX_W-1:0]  slot_idx;
  logic              slot_load;
  logic [CODE_W-1:0] prof_code;

  tgc_ctrl_regs #(.ENTRIES(ENTRIES), .CODE_W(CODE_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .prof_we    (prof_we),
    .prof_waddr (prof_waddr),
    .idle_code  (idle_code),
    .range_hi   (range_hi)
  );

  tgc_profile_mem #(.ENTRIES(ENTRIES), .CODE_W(CODE_W)) u_mem (
    .clk   (clk),
    .we    (prof_we),
    .waddr (prof_waddr),
    .wdata (cfg_wdata),
    .re    (slot_load),
    .raddr (slot_idx),
    .rdata (prof_code)
  );

  tgc_slot_timer #(.ENTRIES(ENTRIES), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .acq_active (acq_active),
    .active_q   (active_q),
    .slot_idx   (slot_idx),
    .slot_load  (slot_load)
  );

  tgc_output_stage #(.CODE_W(CODE_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .active_q  (active_q),
    .prof_code (prof_code),
    .idle_code (idle_code),
    .dac_code  (dac_code),
    .dac_load  (dac_load)
  );

endmodule

// File: rtl/tgc_sequencer_checker.sv
module tgc_sequencer_checker #(
  parameter int ENTRIES = 16,
  parameter int CODE_W  = 9,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ADDR_W = $clog2(ENTRIES + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              wdata_b0,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_load,
  input logic              range_hi,
  input logic              active_q,
  input logic [IDX_W-1:0]  slot_idx,
  input logic [CODE_W-1:0] idle_code
);

  localparam logic [ADDR_W-1:0] RANGE_ADDR = ADDR_W'(ENTRIES + 1);
  localparam logic [IDX_W-1:0]  LAST_SLOT  = IDX_W'(ENTRIES - 1);

  logic [1:0] age;
  logic       past_ok;

  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign past_ok = (age == 2'd3);

  AST_LOAD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && dac_load) |-> (dac_code != $past(dac_code))); // R6
  AST_CHANGE_MEANS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && dac_code != $past(dac_code)) |-> dac_load); // R6
  AST_IDLE_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(active_q, 2)) |-> (dac_code == $past(idle_code))); // R5
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (past_ok && active_q && !$past(active_q)) |-> (slot_idx == '0)); // R8
  AST_HOLD_LAST: assert property (@(posedge clk) disable iff (rst)
    (past_ok && active_q && $past(active_q) && $past(slot_idx) == LAST_SLOT)
      |-> (slot_idx == LAST_SLOT)); // R4
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && active_q && $past(active_q) && slot_idx != $past(slot_idx))
      |-> (slot_idx == $past(slot_idx) + 1'b1)); // R3
  AST_RANGE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cfg_we) && $past(cfg_addr) == RANGE_ADDR)
      |-> (range_hi == $past(wdata_b0))); // R7

endmodule

bind tgc_sequencer tgc_sequencer_checker #(.ENTRIES(ENTRIES), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .wdata_b0  (cfg_wdata[0]),
  .dac_code  (dac_code),
  .dac_load  (dac_load),
  .range_hi  (range_hi),
  .active_q  (active_q),
  .slot_idx  (slot_idx),
  .idle_code (idle_code)
);

// File: tb/tb_tgc_sequencer.sv
module tb_tgc_sequencer;

  localparam int ENTRIES = 16;
  localparam int CODE_W  = 9;
  localparam int SLOT    = 8;
  localparam int ADDR_W  = $clog2(ENTRIES + 2);

  typedef struct {
    int    code;
    int    cyc;
    string req;
  } exp_item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CODE_W-1:0] cfg_wdata = '0;
  logic              acq_active = 1'b0;
  logic [CODE_W-1:0] dac_code;
  logic              dac_load;
  logic              range_hi;

  int        cyc = 0;
  int        n_checks = 0;
  int        n_fail = 0;
  bit        done = 1'b0;
  exp_item_t exp_q[$];
  int        prof[ENTRIES];

  tgc_sequencer #(.ENTRIES(ENTRIES), .CODE_W(CODE_W), .SLOT_CYCLES(SLOT)) dut (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .acq_active (acq_active),
    .dac_code   (dac_code),
    .dac_load   (dac_load),
    .range_hi   (range_hi)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int code, int at, string req);
    exp_item_t it;
    it.code = code; it.cyc = at; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic cfg_write(int addr, int data);
    cfg_we    = 1'b1;
    cfg_addr  = ADDR_W'(addr);
    cfg_wdata = CODE_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_until(int target);
    while (cyc < target) @(negedge clk);
  endtask

  // Monitor: every load strobe pops one expected item
  always @(negedge clk) begin
    if (!rst && dac_load) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R6 actual=unexpected load of %0d expected=no load (cycle %0d)",
                 dac_code, cyc);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        chk(it.req, int'(dac_code), it.code);
        chk(it.req, cyc, it.cyc);
      end
    end
  end

  initial begin
    #(8 * 6000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    int d;
    for (int i = 0; i < ENTRIES; i++) prof[i] = 100 + 27 * i;

    repeat (4) @(negedge clk);
    chk("R1", int'(dac_code), 0);
    chk("R1", int'(dac_load), 0);
    chk("R1", int'(range_hi), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", int'(dac_code), 0);
    chk("R1", int'(range_hi), 0);

    for (int i = 0; i < ENTRIES; i++) cfg_write(i, prof[i]);

    // R2: idle code appears two cycles after the write cycle
    push(450, cyc + 2, "R2");
    cfg_write(ENTRIES, 450);
    repeat (3) @(negedge clk);
    chk("R2", int'(dac_code), 450);

    // R7: range bit one cycle after the write
    cfg_write(ENTRIES + 1, 1);
    chk("R7", int'(range_hi), 1);

    // R3/R4: full profile walk, then hold last entry
    @(negedge clk);
    c = cyc;
    for (int k = 0; k < ENTRIES; k++) push(prof[k], c + 3 + k * SLOT, "R3");
    acq_active = 1'b1;
    wait_until(c + SLOT + 5);
    // R8: overwrite the entry being driven during its own slot
    cfg_write(1, 77);
    @(negedge clk);
    chk("R8", int'(dac_code), prof[1]);
    prof[1] = 77;
    d = c + ENTRIES * SLOT + 20;
    wait_until(d);
    chk("R4", int'(dac_code), prof[ENTRIES-1]);
    push(450, d + 3, "R5");
    acq_active = 1'b0;
    repeat (10) @(negedge clk);

    // R8/R5: restart from entry 0, abort mid-profile
    c = cyc;
    push(prof[0], c + 3, "R8");
    push(prof[1], c + 3 + SLOT, "R8");
    push(prof[2], c + 3 + 2 * SLOT, "R3");
    acq_active = 1'b1;
    d = c + 2 * SLOT + 4;
    wait_until(d);
    push(450, d + 3, "R5");
    acq_active = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5", int'(dac_code), 450);

    // R9: unused addresses have no effect
    cfg_write(ENTRIES + 2, 511);
    cfg_write(ENTRIES + 3, 0);
    repeat (4) @(negedge clk);
    chk("R9", int'(dac_code), 450);
    chk("R9", int'(range_hi), 1);

    // R7: clearing the range bit
    cfg_write(ENTRIES + 1, 0);
    chk("R7", int'(range_hi), 0);

    // R9: profile unchanged after unused writes (short acquisition)
    c = cyc;
    push(prof[0], c + 3, "R9");
    acq_active = 1'b1;
    d = c + 4;
    wait_until(d);
    push(450, d + 3, "R5");
    acq_active = 1'b0;
    repeat (6) @(negedge clk);

    // R2: second idle value
    push(300, cyc + 2, "R2");
    cfg_write(ENTRIES, 300);
    repeat (4) @(negedge clk);
    chk("R2", int'(dac_code), 300);
    chk("R6", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule